// File: doc/BRIEF.md
# Programmable Timer Counter Channel

This block is one down-counting channel of an interval timer. A load strobe writes a start value and a counting mode. After that the counter steps only on cycles where the count-enable tick is high. A gate input either holds counting at its level or restarts it on a rising edge, depending on the mode. The live count can be read at all times. A single output level follows the waveform of the selected mode: a terminal-count flag, a one-shot, a rate pulse, a square wave, or a strobe. This output can drive an interrupt request.

Six modes are provided, numbered 0 to 5. Codes 6 and 7 are folded onto 2 and 3. A start value of zero stands for the full range of 2^16. Modes 2 and 3 reload themselves from the start value every period. The other modes run past zero and wrap around. The channel stays idle from reset until its first load.

Top module: `tmr_chan`

## Requirements
- R1: A start value of 0 counts as 65536. The count reads 0 after the load and 0xFFFF after one step. In mode 0 the output rises on the 65536th step.
- R2: A load sets the count to load_val on the next cycle and takes priority over a tick in the same cycle. The mode input is sampled only on a load, so later changes to it have no effect until the next load.
- R3: In modes 0, 1, 4 and 5 each step subtracts one, and the count wraps from 0 to 0xFFFF without reloading.
- R4: Mode 3 subtracts two per step. On a step taken while the count is 2 or less, the count reloads and the output toggles. A load or a restart sets the output high.
- R5: Mode 2 subtracts one per step and reloads from the start value on the step taken at count 1. The output is low exactly while the count is 1.
- R6: The gate is sampled on tick cycles and on the load cycle. In modes 1, 2, 3 and 5, a tick that sees gate high after a low sample restarts the count from the start value. In modes 0 and 4 such an edge has no restart effect.
- R7: In modes 0, 2, 3 and 4 a low gate suspends stepping. In modes 1 and 5 the gate level does not stop counting.
- R8: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R9: In mode 0 the output goes low on load. It goes high on the step from 1 to 0 and stays high until the next load.
- R10: In mode 1 a load sets the output high. A gate restart drives it low, and the step from 1 to 0 drives it high again.
- R11: In modes 4 and 5 the output is high after load. It drops for one step on the step from 1 to 0 and returns high on the following step.
- R12: With neither tick nor load, count and output hold their values.
- R13: After reset the count and output are 0, and ticks have no effect until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| gate | input | 1 | Gate level, sampled on tick and load |
| mode | input | 3 | Counting mode, sampled on load |
| load | input | 1 | Load strobe for start value and mode |
| load_val | input | 16 | Start value, 0 meaning 65536 |
| count | output | 16 | Live counter value |
| out | output | 1 | Mode-dependent output level |

## Verification
Some properties are checked on every cycle:
- the count takes the loaded value;
- count and output hold while no tick or load arrives;
- the output is low after a mode 0 load;
- the modes 1 and 5 count wraps from zero;
- mode 2 reloads at count 1;
- mode 3 steps down by two;
- the channel stays idle before its first load.

Other behaviour is shown only by the directed scenarios:
- full waveforms over periods: square-wave toggling with even and odd start values, strobe timing and one-shot retriggering;
- the 65536-step terminal count of a zero load;
- gate edge restarts placed mid-count;
- folding of codes 6 and 7.

// File: rtl/tmr_pkg.sv
// Shared types for the timer channel: mode encoding, per-mode control
// bundle, and the fold of the two alias codes onto their base modes.
package tmr_pkg;

    typedef enum logic [2:0] {
        MD_TC_INT  = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SW_STB  = 3'd4,
        MD_HW_STB  = 3'd5
    } tmr_mode_e;

    typedef struct packed {
        logic reload;     // period auto-reload
        logic step2;      // step by two
        logic gate_hold;  // low gate suspends stepping
        logic gate_edge;  // rising gate restarts
    } tmr_ctl_t;

    // Codes 6 and 7 map to 2 and 3.
    function automatic tmr_mode_e fold_mode(input logic [2:0] m);
        if (m[2] && m[1]) begin
            return tmr_mode_e'({1'b0, m[1:0]});
        end
        return tmr_mode_e'(m);
    endfunction

endpackage

// File: rtl/tmr_mode_reg.sv
// Mode register and decoder. Captures the folded mode on a load and
// turns it into the control bundle used by the counter.
// Assumes: mode input is only meaningful in a load cycle.
module tmr_mode_reg
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  tmr_mode_e     mode_in,
    output tmr_mode_e     mode_q,
    output tmr_ctl_t      ctl
);

    // Hold the mode chosen by the latest load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_TC_INT;
        end else if (load) begin
            mode_q <= mode_in;
        end
    end

    // Decode the stored mode into counter controls.
    always_comb begin
        ctl = '0;
        case (mode_q)
            MD_TC_INT:  ctl = '{reload: 1'b0, step2: 1'b0, gate_hold: 1'b1, gate_edge: 1'b0};
            MD_ONESHOT: ctl = '{reload: 1'b0, step2: 1'b0, gate_hold: 1'b0, gate_edge: 1'b1};
            MD_RATE:    ctl = '{reload: 1'b1, step2: 1'b0, gate_hold: 1'b1, gate_edge: 1'b1};
            MD_SQUARE:  ctl = '{reload: 1'b1, step2: 1'b1, gate_hold: 1'b1, gate_edge: 1'b1};
            MD_SW_STB:  ctl = '{reload: 1'b0, step2: 1'b0, gate_hold: 1'b1, gate_edge: 1'b0};
            MD_HW_STB:  ctl = '{reload: 1'b0, step2: 1'b0, gate_hold: 1'b0, gate_edge: 1'b1};
            default:    ctl = '0;
        endcase
    end

endmodule

// File: rtl/tmr_gate_det.sv
// Gate sampler. Samples the gate on tick cycles and on the load cycle,
// and flags a rising edge against the previous sample.
// Assumes: gate is already synchronous to clk.
module tmr_gate_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  logic gate,
    output logic gate_q,
    output logic rise
);

    // Keep the reference gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (tick || load) begin
            gate_q <= gate;
        end
    end

    // Edge seen by a tick, relative to the previous sample.
    always_comb begin
        rise = tick && gate && !gate_q;
    end

endmodule

// File: rtl/tmr_count_core.sv
// Counter datapath. Holds the start value one bit wider than the count
// so that a zero load can stand for the full range. Produces the step
// and restart events for the output generator.
// Assumes: ctl is stable between loads.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             rise,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  tmr_ctl_t         ctl,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    init,
    output logic             run,
    output logic             trig,
    output logic             step
);

    localparam logic [CW-1:0] FULL  = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CW-1:0] WRAPM = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] TWO   = CW'(2);

    logic [CW-1:0] ld_ext;
    logic [CW-1:0] cnt_nxt;

    // Widen the load value; zero means the full range.
    always_comb begin
        ld_ext = (load_val == '0) ? FULL : {1'b0, load_val};
    end

    // Restart and step qualifiers for this cycle.
    always_comb begin
        trig = run && rise && ctl.gate_edge;
        step = run && tick && !trig && (gate || !ctl.gate_hold);
    end

    // Next count for a plain step in the current mode.
    always_comb begin
        if (ctl.reload && ctl.step2) begin
            cnt_nxt = (cnt <= TWO) ? init : cnt - TWO;
        end else if (ctl.reload) begin
            cnt_nxt = (cnt == ONE) ? init : cnt - ONE;
        end else begin
            cnt_nxt = (cnt - ONE) & WRAPM;
        end
    end

    // Count, start value and run flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            init <= FULL;
            run  <= 1'b0;
        end else if (load) begin
            cnt  <= ld_ext;
            init <= ld_ext;
            run  <= 1'b1;
        end else if (trig) begin
            cnt  <= init;
        end else if (step) begin
            cnt  <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tmr_out_gen.sv
// Output waveform generator. Tracks the per-mode output level from the
// load, restart and step events and the count before each step.
// Assumes: events come from the counter in the same cycle.
module tmr_out_gen
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CW   = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  tmr_mode_e     ld_mode,
    input  tmr_mode_e     mode_q,
    input  logic          run,
    input  logic          trig,
    input  logic          step,
    input  logic [CW-1:0] cnt,
    output logic          out
);

    logic out_q;
    logic at_one;
    logic at_end2;

    // Count landmarks used by the waveforms.
    always_comb begin
        at_one  = (cnt == CW'(1));
        at_end2 = (cnt <= CW'(2));
    end

    // Registered output level for all modes except the rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (load) begin
            out_q <= (ld_mode != MD_TC_INT);
        end else if (trig) begin
            out_q <= (mode_q != MD_ONESHOT);
        end else if (step) begin
            case (mode_q)
                MD_TC_INT, MD_ONESHOT: if (at_one) out_q <= 1'b1;
                MD_SQUARE:             if (at_end2) out_q <= !out_q;
                MD_SW_STB, MD_HW_STB:  out_q <= !at_one;
                default:               out_q <= 1'b1;
            endcase
        end
    end

    // Rate mode drives low only while the count sits at one.
    always_comb begin
        if (!run) begin
            out = 1'b0;
        end else if (mode_q == MD_RATE) begin
            out = !at_one;
        end else begin
            out = out_q;
        end
    end

endmodule

// File: rtl/tmr_chan.sv
// Top of one timer channel: mode register, gate sampler, counter
// datapath and output generator.
// Assumes: all inputs synchronous to clk; reset is synchronous, low.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic [2:0]       mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             out
);

    tmr_mode_e     ld_mode;
    tmr_mode_e     mode_q;
    tmr_ctl_t      ctl;
    logic          gate_q;
    logic          rise;
    logic [CW-1:0] cnt;
    logic [CW-1:0] init;
    logic          run;
    logic          trig;
    logic          step;

    // Fold alias codes before they are stored.
    always_comb begin
        ld_mode = fold_mode(mode);
    end

    tmr_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .mode_in (ld_mode),
        .mode_q  (mode_q),
        .ctl     (ctl)
    );

    tmr_gate_det u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (load),
        .gate   (gate),
        .gate_q (gate_q),
        .rise   (rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .rise     (rise),
        .load     (load),
        .load_val (load_val),
        .ctl      (ctl),
        .cnt      (cnt),
        .init     (init),
        .run      (run),
        .trig     (trig),
        .step     (step)
    );

    tmr_out_gen #(.CNT_W(CNT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_mode (ld_mode),
        .mode_q  (mode_q),
        .run     (run),
        .trig    (trig),
        .step    (step),
        .cnt     (cnt),
        .out     (out)
    );

    // Live count readback drops the range bit.
    always_comb begin
        count = cnt[CNT_W-1:0];
    end

endmodule

// File: rtl/tmr_chan_chk.sv
// Property checker for the timer channel, bound to the top module.
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CW   = CNT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate,
    input logic [2:0]       mode,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count,
    input logic             out,
    input tmr_mode_e        mode_q,
    input logic [CW-1:0]    init,
    input logic             gate_q,
    input logic             run
);

    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(count) && $stable(out)));

    a_r9_low_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == 3'd0) |=> !out);

    a_r3_oneshot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !gate && (mode_q == MD_ONESHOT || mode_q == MD_HW_STB)
         && count == '0) |=> count == {CNT_W{1'b1}});

    a_r5_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gate && !load && mode_q == MD_RATE && count == CNT_W'(1))
        |=> count == $past(init[CNT_W-1:0]));

    a_r4_square_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gate && gate_q && !load && mode_q == MD_SQUARE && count > CNT_W'(2))
        |=> count == $past(count) - CNT_W'(2));

    a_r13_idle_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (count == '0 && !out));

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gate     (gate),
    .mode     (mode),
    .load     (load),
    .load_val (load_val),
    .count    (count),
    .out      (out),
    .mode_q   (mode_q),
    .init     (init),
    .gate_q   (gate_q),
    .run      (run)
);

// File: tb/tmr_chan_tb_top.sv
// Directed bench for the timer channel: one task per scenario.
module tmr_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        load = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count;
    logic        out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = !clk;

    tmr_chan dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .mode     (mode),
        .load     (load),
        .load_val (load_val),
        .count    (count),
        .out      (out)
    );

    task automatic chk(input string tag, input logic [15:0] exp_cnt, input logic exp_out);
        n_chk++;
        if (count !== exp_cnt || out !== exp_out) begin
            n_fail++;
            $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                     tag, count, out, exp_cnt, exp_out);
        end
    endtask

    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        load = 1'b1; mode = m; load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R13 reset", 16'h0000, 1'b0);
        gate = 1'b1;
        ticks(3);
        chk("R13 no count before load", 16'h0000, 1'b0);
    endtask

    task automatic t_mode0;
        gate = 1'b1;
        do_load(3'd0, 16'd5);
        chk("R9 R2 mode0 load", 16'd5, 1'b0);
        ticks(4);
        chk("R3 mode0 at 1", 16'd1, 1'b0);
        ticks(1);
        chk("R9 terminal high", 16'd0, 1'b1);
        ticks(1);
        chk("R3 R9 wrap stays high", 16'hFFFF, 1'b1);
        gate = 1'b0;
        ticks(3);
        chk("R7 mode0 gate low holds", 16'hFFFF, 1'b1);
        gate = 1'b1;
        ticks(1);
        chk("R6 mode0 edge no restart", 16'hFFFE, 1'b1);
        repeat (5) @(negedge clk);
        chk("R12 idle hold", 16'hFFFE, 1'b1);
        tick = 1'b1;
        do_load(3'd0, 16'd100);
        tick = 1'b0;
        chk("R2 load beats tick", 16'd100, 1'b0);
    endtask

    task automatic t_zero;
        gate = 1'b1;
        do_load(3'd0, 16'd0);
        chk("R1 zero load reads 0", 16'd0, 1'b0);
        ticks(1);
        chk("R1 first step", 16'hFFFF, 1'b0);
        ticks(65534);
        chk("R1 step 65535", 16'd1, 1'b0);
        ticks(1);
        chk("R1 step 65536 terminal", 16'd0, 1'b1);
    endtask

    task automatic t_mode2;
        gate = 1'b1;
        do_load(3'd2, 16'd4);
        chk("R5 mode2 load", 16'd4, 1'b1);
        ticks(3);
        chk("R5 low at 1", 16'd1, 1'b0);
        ticks(1);
        chk("R5 reload", 16'd4, 1'b1);
        ticks(2);
        gate = 1'b0;
        ticks(1);
        chk("R7 mode2 gate low holds", 16'd2, 1'b1);
        gate = 1'b1;
        ticks(1);
        chk("R6 mode2 restart", 16'd4, 1'b1);
        ticks(1);
        chk("R5 after restart", 16'd3, 1'b1);
        do_load(3'd6, 16'd3);
        ticks(2);
        chk("R8 code6 low at 1", 16'd1, 1'b0);
        ticks(1);
        chk("R8 code6 reload", 16'd3, 1'b1);
        do_load(3'd2, 16'd3);
        mode = 3'd0;
        ticks(3);
        chk("R2 mode sampled only at load", 16'd3, 1'b1);
    endtask

    task automatic t_mode3;
        gate = 1'b1;
        do_load(3'd3, 16'd6);
        chk("R4 mode3 load", 16'd6, 1'b1);
        ticks(2);
        chk("R4 step by two", 16'd2, 1'b1);
        ticks(1);
        chk("R4 half period toggle", 16'd6, 1'b0);
        ticks(3);
        chk("R4 second half", 16'd6, 1'b1);
        do_load(3'd3, 16'd5);
        ticks(2);
        chk("R4 odd count", 16'd1, 1'b1);
        ticks(1);
        chk("R4 odd reload", 16'd5, 1'b0);
        do_load(3'd7, 16'd4);
        ticks(1);
        chk("R8 code7 step", 16'd2, 1'b1);
        ticks(1);
        chk("R8 code7 toggle", 16'd4, 1'b0);
        do_load(3'd3, 16'd8);
        chk("R4 load sets high", 16'd8, 1'b1);
        ticks(1);
        gate = 1'b0;
        ticks(1);
        chk("R7 mode3 gate low holds", 16'd6, 1'b1);
        gate = 1'b1;
        ticks(1);
        chk("R6 mode3 restart", 16'd8, 1'b1);
    endtask

    task automatic t_mode1;
        gate = 1'b0;
        do_load(3'd1, 16'd3);
        chk("R10 mode1 load high", 16'd3, 1'b1);
        gate = 1'b1;
        ticks(1);
        chk("R10 R6 trigger low", 16'd3, 1'b0);
        ticks(2);
        chk("R10 counting low", 16'd1, 1'b0);
        ticks(1);
        chk("R10 terminal high", 16'd0, 1'b1);
        ticks(1);
        chk("R3 mode1 wrap", 16'hFFFF, 1'b1);
        gate = 1'b0;
        ticks(1);
        chk("R7 mode1 gate low counts", 16'hFFFE, 1'b1);
    endtask

    task automatic t_mode45;
        gate = 1'b1;
        do_load(3'd4, 16'd2);
        chk("R11 mode4 load", 16'd2, 1'b1);
        ticks(1);
        chk("R11 mode4 at 1", 16'd1, 1'b1);
        ticks(1);
        chk("R11 mode4 strobe", 16'd0, 1'b0);
        ticks(1);
        chk("R11 R3 mode4 after strobe", 16'hFFFF, 1'b1);
        gate = 1'b0;
        ticks(1);
        chk("R7 mode4 gate low holds", 16'hFFFF, 1'b1);
        do_load(3'd5, 16'd2);
        ticks(1);
        chk("R7 mode5 counts gate low", 16'd1, 1'b1);
        gate = 1'b1;
        ticks(1);
        chk("R6 mode5 restart", 16'd2, 1'b1);
        ticks(2);
        chk("R11 mode5 strobe", 16'd0, 1'b0);
        ticks(1);
        chk("R11 mode5 after strobe", 16'hFFFF, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_zero();
        t_mode2();
        t_mode3();
        t_mode1();
        t_mode45();
        finish_run();
    end

    initial begin
        #(190000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule